// File: doc/BRIEF.md
# Two-Pulse Test Mode Entry Controller

This block picks the chip's test mode. A 5-bit request code arrives on the interrupt-request lines. The mode is committed by two active-low pulses on a single test pin. When the first pulse ends (the test pin goes high again), the controller captures the code on the bus. When the second pulse ends, it makes that captured code the active mode. Until the second pulse ends, the mode that was active before stays in force. The same two-pulse sequence changes to another mode, and running it with code `00000` returns the chip to normal operation.

The controller decodes the active mode into registered controls: five individual scan-chain enables, an all-chains flag and a global output tri-state request. The test pin is asynchronous to the block clock, so it passes through a synchronizer before its rising edges are detected. While the power-good input is low, the controller holds normal mode and discards any half-finished sequence. The asynchronous active-low reset does the same.

Top module: `tmode_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. The first test-pin rising edge after reset is treated as the end of a first pulse.
- R2: A test-pin rising edge that ends a first pulse captures `irq_code` as sampled at the detecting clock edge, and changes no output.
- R3: Let E1 be the first clock edge that samples `test_n` high at the end of a pulse. The `irq_code` value present at the third such edge (E3) is the one used. When the pulse is a second pulse, the outputs take the new mode at E3 and not before.
- R4: Applied codes 1 to 5 (`00001` to `00101`) set only `chain_en[code-1]`. `all_chains` and `tristate_all` stay 0.
- R5: Applied code `11111` sets all five `chain_en` bits and `all_chains`, with `tristate_all` at 0.
- R6: Applied code `01001` sets only `tristate_all`.
- R7: Applied code `00000`, or any code not listed in R4 to R6, drives all outputs to 0.
- R8: The value on `irq_code` during the second pulse is ignored. The code captured at the first pulse is the one applied.
- R9: When `pwr_ok` is low at a clock edge, all outputs clear at that edge and any captured first pulse is discarded. This holds even when a second-pulse edge falls in the same cycle: the clear wins.
- R10: At most one of the following is active at a time: a single chain enable, the all-chains mode, or the tri-state request. All-chains is the only case in which more than one `chain_en` bit is set.
- R11: Outputs change only at an edge that applies a mode or at a power-good clear. Otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power good; low holds normal mode |
| test_n | input | 1 | Asynchronous active-low test pin |
| irq_code | input | 5 | Requested mode code (interrupt lines 7 to 3) |
| chain_en | output | 5 | Per-chain scan enables |
| all_chains | output | 1 | All-chains mode active |
| tristate_all | output | 1 | Request to tri-state all outputs |

## Verification
The second-pulse apply and the power-good clear can fall on the same clock edge. The bench provokes this by dropping `pwr_ok` so that it is sampled at E3 of a second pulse. It expects the outputs to read all zero afterwards. It then restores power and sends one full pulse, which must act only as a fresh capture and leave the outputs at zero. Only a further pulse may apply a mode, and it must apply the freshly captured code.

// File: rtl/tme_pkg.sv
package tme_pkg;
  localparam int TME_CODE_W = 5;
  localparam int TME_CHAINS = 5;
  localparam logic [TME_CODE_W-1:0] TME_CODE_NONE = 5'b00000;
  localparam logic [TME_CODE_W-1:0] TME_CODE_ALL  = 5'b11111;
  localparam logic [TME_CODE_W-1:0] TME_CODE_TRI  = 5'b01001;

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_state_e;

  typedef struct packed {
    logic                  tri_req;
    logic                  all_req;
    logic [TME_CHAINS-1:0] chains;
  } mode_ctl_t;
endpackage

// File: rtl/tme_pin_sync.sv
module tme_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  // Idle level of the pin is high; reset to it so no false edge appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[LAST-1:0], pin_n};
      prev_q  <= chain_q[LAST];
    end
  end

  assign rise = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/tme_sequencer.sv
module tme_sequencer
  import tme_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  rise,
  input  logic [TME_CODE_W-1:0] code_in,
  output logic                  apply,
  output logic [TME_CODE_W-1:0] apply_code,
  output logic                  armed
);
  seq_state_e            state_q, state_d;
  logic [TME_CODE_W-1:0] cap_q;

  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = SEQ_IDLE;
    end else if (rise) begin
      state_d = (state_q == SEQ_IDLE) ? SEQ_ARMED : SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cap_q   <= TME_CODE_NONE;
    end else begin
      state_q <= state_d;
      if (!clear && rise && state_q == SEQ_IDLE) begin
        cap_q <= code_in;
      end
    end
  end

  assign apply      = rise & ~clear & (state_q == SEQ_ARMED);
  assign apply_code = cap_q;
  assign armed      = (state_q == SEQ_ARMED);
endmodule

// File: rtl/tme_decode.sv
module tme_decode
  import tme_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  apply,
  input  logic [TME_CODE_W-1:0] code,
  output mode_ctl_t             ctl
);
  logic [TME_CHAINS-1:0] hit;
  mode_ctl_t             dec;

  for (genvar g = 0; g < TME_CHAINS; g++) begin : g_chain
    assign hit[g] = (code == TME_CODE_W'(g + 1));
  end

  always_comb begin
    dec = '0;
    if (code == TME_CODE_ALL) begin
      dec.all_req = 1'b1;
      dec.chains  = '1;
    end else if (code == TME_CODE_TRI) begin
      dec.tri_req = 1'b1;
    end else begin
      dec.chains = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (clear) begin
      ctl <= '0;
    end else if (apply) begin
      ctl <= dec;
    end
  end
endmodule

// File: rtl/tmode_entry_ctrl.sv
module tmode_entry_ctrl
  import tme_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_ok,
  input  logic                  test_n,
  input  logic [TME_CODE_W-1:0] irq_code,
  output logic [TME_CHAINS-1:0] chain_en,
  output logic                  all_chains,
  output logic                  tristate_all
);
  logic                  rise_w;
  logic                  apply_w;
  logic                  armed_w;
  logic                  clear_w;
  logic [TME_CODE_W-1:0] code_w;
  mode_ctl_t             ctl_w;

  assign clear_w = ~pwr_ok;

  tme_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin_n(test_n),
    .rise (rise_w)
  );

  tme_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear_w),
    .rise      (rise_w),
    .code_in   (irq_code),
    .apply     (apply_w),
    .apply_code(code_w),
    .armed     (armed_w)
  );

  tme_decode u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear_w),
    .apply(apply_w),
    .code (code_w),
    .ctl  (ctl_w)
  );

  assign chain_en     = ctl_w.chains;
  assign all_chains   = ctl_w.all_req;
  assign tristate_all = ctl_w.tri_req;
endmodule

// File: rtl/tmode_entry_ctrl_sva.sv
module tmode_entry_ctrl_sva
  import tme_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwr_ok,
  input logic                  rise,
  input logic                  armed,
  input logic [TME_CHAINS-1:0] chain_en,
  input logic                  all_chains,
  input logic                  tristate_all
);
  a_r9_clear_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (chain_en == '0 && !all_chains && !tristate_all));

  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !armed);

  a_r5_all_sets_chains: assert property (@(posedge clk) disable iff (!rst_n)
    all_chains |-> (chain_en == '1 && !tristate_all));

  a_r10_tri_alone: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_all |-> (chain_en == '0 && !all_chains));

  a_r10_single_chain: assert property (@(posedge clk) disable iff (!rst_n)
    !all_chains |-> $onehot0(chain_en));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !(rise && armed)) |=>
      ($stable(chain_en) && $stable(all_chains) && $stable(tristate_all)));

  a_r2_first_edge_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && rise && !armed) |=> armed);
endmodule

bind tmode_entry_ctrl tmode_entry_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .rise        (rise_w),
  .armed       (armed_w),
  .chain_en    (chain_en),
  .all_chains  (all_chains),
  .tristate_all(tristate_all)
);

// File: tb/tmode_entry_ctrl_test.sv
module tmode_entry_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       test_n = 1'b1;
  logic [4:0] irq_code = 5'd0;
  logic [4:0] chain_en;
  logic       all_chains;
  logic       tristate_all;

  int unsigned tests = 0;
  int unsigned fails = 0;
  logic [6:0]  cur_exp = 7'd0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  tmode_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .test_n(test_n),
    .irq_code(irq_code), .chain_en(chain_en), .all_chains(all_chains),
    .tristate_all(tristate_all)
  );

  // {tristate_all, all_chains, chain_en}
  function automatic logic [6:0] exp_ctl(input logic [4:0] c);
    if (c == 5'b11111) return {2'b01, 5'b11111};
    if (c == 5'b01001) return {2'b10, 5'b00000};
    if (c >= 5'd1 && c <= 5'd5) return {2'b00, 5'(1 << (c - 1))};
    return 7'd0;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {tristate_all, all_chains, chain_en};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One pulse with code on the bus; stops at negedge after E2 (not yet applied)
  task automatic pulse_to_e2(input logic [4:0] c);
    irq_code = c;
    test_n = 1'b0;
    cyc(3);
    test_n = 1'b1;
    cyc(2);
  endtask

  task automatic first_pulse(input logic [4:0] c, input string req);
    pulse_to_e2(c);
    cyc(2);
    check(req, cur_exp);
  endtask

  task automatic second_pulse(input logic [4:0] c_first, input logic [4:0] c_bus, input string req);
    pulse_to_e2(c_bus);
    check("R3 before E3", cur_exp);
    cyc(1);
    cur_exp = exp_ctl(c_first);
    check(req, cur_exp);
    cyc(1);
  endtask

  task automatic sequence2(input logic [4:0] c, input logic [4:0] c2, input string req);
    first_pulse(c, "R2 capture no change");
    second_pulse(c, c2, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0] rc, rc2;
    seed_v = 32'd2024;
    void'($urandom(seed_v));
    cyc(2);
    check("R1 reset", 7'd0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 after reset", 7'd0);

    for (int k = 1; k <= 5; k++) sequence2(5'(k), 5'd0, "R4 single chain");
    sequence2(5'b11111, 5'd0, "R5 all chains");
    sequence2(5'b01001, 5'd0, "R6 tristate");
    sequence2(5'b00000, 5'd0, "R7 none");
    sequence2(5'd3, 5'd0, "R4 chain3");
    sequence2(5'b10110, 5'd0, "R7 undefined");
    sequence2(5'd2, 5'b11111, "R8 second bus ignored");
    sequence2(5'b01001, 5'd4, "R8 second bus ignored");

    // R9: clear in the same cycle as the second-pulse apply edge
    sequence2(5'd1, 5'd0, "R4 setup");
    first_pulse(5'd5, "R2 capture");
    pulse_to_e2(5'd0);
    pwr_ok = 1'b0;
    cyc(1);
    cur_exp = 7'd0;
    check("R9 clear wins over apply", cur_exp);
    cyc(2);
    pwr_ok = 1'b1;
    cyc(2);
    first_pulse(5'd4, "R9 first pulse after clear only captures");
    second_pulse(5'd4, 5'd2, "R9 fresh capture applied");

    // R9: clear discards a half sequence
    first_pulse(5'b11111, "R2 capture");
    pwr_ok = 1'b0;
    cyc(2);
    cur_exp = 7'd0;
    check("R9 clear outputs", cur_exp);
    pwr_ok = 1'b1;
    cyc(2);
    first_pulse(5'd1, "R9 discarded arm");
    second_pulse(5'd1, 5'd0, "R9 new sequence");

    // R1: reset mid-sequence
    first_pulse(5'd2, "R2 capture");
    rst_n = 1'b0;
    cyc(2);
    cur_exp = 7'd0;
    check("R1 reset clears", cur_exp);
    rst_n = 1'b1;
    cyc(2);
    first_pulse(5'd3, "R1 first after reset");
    second_pulse(5'd3, 5'd0, "R1 then apply");

    for (int n = 0; n < 40; n++) begin
      case ($urandom % 4)
        0: rc = 5'(1 + ($urandom % 5));
        1: rc = 5'b11111;
        2: rc = 5'b01001;
        default: rc = 5'($urandom);
      endcase
      rc2 = 5'($urandom);
      sequence2(rc, rc2, "R3 random apply");
      cyc(1);
      check("R11 hold", cur_exp);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule